// File: doc/BRIEF.md
# FSK byte receiver with serial readout

This block sits behind an FSK demodulator and turns its raw bit stream into characters. The stream is asynchronous at 1200 baud. A system clock is divided down to sixteen ticks per bit period. Those ticks locate each start bit and sample every following bit at its centre.

When a character completes, the eight data bits and the received stop bit are loaded into a nine-bit holding register at the centre of the stop bit. At the same moment an active-low ready strobe is raised. An external controller reads the register one bit at a time by toggling a shift clock. The controller may stop after eight clocks if it does not need the stop bit.

The strobe is withdrawn by the first rising edge of the shift clock, or after half a bit period if no edge arrives. An active-low carrier-detect input gates the whole receiver. A power-down input parks both outputs high.

Top module: `fsk_byte_reader`

## Requirements
- R1: A character begins when the synchronized line, sampled on oversampling ticks, goes from high to low. If the line is high again at the start bit's centre (eight ticks later), the receiver drops back to idle and nothing is loaded.
- R2: After a confirmed start bit, each data bit and the stop bit is sampled sixteen ticks after the previous sample. At the stop-bit sample, the frame is loaded and `dr_n` goes low, about 9.5 bit periods after the start edge.
- R3: `sdo` always presents bit 0 of the holding register. Each rising edge of `sclk` shifts the register by one place toward `sdo`. Bits leave in arrival order: data bit 0 first, data bit 7 eighth, stop bit ninth. After reset the register holds all ones.
- R4: If `sclk` rises while `dr_n` is low, `dr_n` returns high in response to that edge.
- R5: If no `sclk` edge arrives, `dr_n` returns high eight ticks (half a bit) after it fell.
- R6: While `cd_n` is high, the receiver ignores `rx_raw` and loads nothing, so the holding register keeps its contents. `dr_n` is held high during this time.
- R7: While `pwr_dn` is high, `sdo` and `dr_n` are high from the next clock onward. No character is received in power-down.
- R8: A read of only eight clocks is allowed. The next completed character overwrites whatever was left in the register.
- R9: Each `sclk` rising edge after all nine stored bits have left the register shifts in a one.
- R10: The stop bit is stored exactly as received, so a low stop bit appears as a 0 at the ninth read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_dn | input | 1 | Power-down request, active high |
| cd_n | input | 1 | Carrier detect, active low, asynchronous |
| rx_raw | input | 1 | Raw demodulated bit stream, asynchronous |
| sclk | input | 1 | Controller-driven shift clock, asynchronous |
| dr_n | output | 1 | Data-ready strobe, active low |
| sdo | output | 1 | Serial data out, head bit of the holding register |

## Verification
The bench sends a short pulse too brief to be a start bit. A receiver that skipped the mid-start confirmation would load a phantom character and raise a strobe that no queued item matches.

It reads with nine clocks, then eight, then nine again. It also adds extra clocks past the ninth. A register that shifted in zeros, shifted in the wrong direction, or failed to reload over a partly read byte would give wrong bits at the tail.

A frame with a low stop bit checks that the ninth bit is not forced to one. Letting the strobe time out, and then receiving with carrier dropped, shows whether the strobe stays low too long or whether a byte arriving without carrier corrupts the stored one.

// File: rtl/fsk_rx_pkg.sv
package fsk_rx_pkg;

    localparam int CHAR_BITS  = 8;
    localparam int FRAME_BITS = CHAR_BITS + 1;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic                 stop;
        logic [CHAR_BITS-1:0] data;
    } rx_frame_t;

    // Register image: data bit 0 at index 0 (first out), stop bit at the top.
    function automatic logic [FRAME_BITS-1:0] frame_image(rx_frame_t f);
        return {f.stop, f.data};
    endfunction

endpackage

// File: rtl/fsk_sync2.sv
module fsk_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fsk_tick_gen.sv
module fsk_tick_gen #(
    parameter int DIV = 13021
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/fsk_char_rx.sv
module fsk_char_rx
    import fsk_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      tick,
    input  logic      rx_s,
    output logic      load,
    output rx_frame_t frame
);
    localparam int PW = $clog2(OVS);
    localparam int IW = $clog2(CHAR_BITS);
    localparam logic [PW-1:0] MID_PH  = PW'(OVS / 2 - 1);
    localparam logic [PW-1:0] LAST_PH = PW'(OVS - 1);
    localparam logic [IW-1:0] LAST_IX = IW'(CHAR_BITS - 1);

    rx_state_e            state;
    logic [PW-1:0]        phase;
    logic [IW-1:0]        idx;
    logic [CHAR_BITS-1:0] acc;
    logic                 prev_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '1;
        end
        if (rst || !enable) begin
            state   <= RX_IDLE;
            phase   <= '0;
            idx     <= '0;
            acc     <= '0;
            prev_rx <= 1'b1;
            load    <= 1'b0;
        end else begin
            load <= 1'b0;
            if (tick) begin
                prev_rx <= rx_s;
                unique case (state)
                    RX_IDLE: begin
                        if (prev_rx && !rx_s) begin
                            state <= RX_START;
                            phase <= '0;
                        end
                    end
                    RX_START: begin
                        if (phase == MID_PH) begin
                            phase <= '0;
                            idx   <= '0;
                            state <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (phase == LAST_PH) begin
                            phase <= '0;
                            acc   <= {rx_s, acc[CHAR_BITS-1:1]};
                            if (idx == LAST_IX) state <= RX_STOP;
                            else                idx   <= idx + 1'b1;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (phase == LAST_PH) begin
                            phase      <= '0;
                            frame.data <= acc;
                            frame.stop <= rx_s;
                            load       <= 1'b1;
                            state      <= RX_IDLE;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/fsk_readout.sv
module fsk_readout
    import fsk_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwr_dn,
    input  logic                  carrier_on,
    input  logic                  tick,
    input  logic                  sclk,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] image,
    output logic                  sclk_rise,
    output logic                  dr_n,
    output logic                  sdo
);
    localparam int HOLD = OVS / 2;
    localparam int HW   = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD - 1);

    logic                  sclk_s, sclk_prev;
    logic [FRAME_BITS-1:0] sreg;
    logic                  dr_q;
    logic [HW-1:0]         hold_cnt;

    fsk_sync2 #(.RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst(rst), .d(sclk), .q(sclk_s)
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_prev;

    always_ff @(posedge clk) begin
        if (rst || pwr_dn) begin
            sreg     <= '1;
            dr_q     <= 1'b0;
            hold_cnt <= '0;
        end else if (load) begin
            sreg     <= image;
            dr_q     <= 1'b1;
            hold_cnt <= '0;
        end else begin
            if (sclk_rise) begin
                sreg <= {1'b1, sreg[FRAME_BITS-1:1]};
                dr_q <= 1'b0;
            end else if (dr_q && tick) begin
                if (hold_cnt == HOLD_LAST) dr_q <= 1'b0;
                else                       hold_cnt <= hold_cnt + 1'b1;
            end
            if (!carrier_on) dr_q <= 1'b0;
        end
    end

    assign dr_n = ~dr_q;
    assign sdo  = sreg[0];
endmodule

// File: rtl/fsk_byte_reader.sv
module fsk_byte_reader
    import fsk_rx_pkg::*;
#(
    parameter int TICK_DIV = 13021,
    parameter int OVS      = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_dn,
    input  logic cd_n,
    input  logic rx_raw,
    input  logic sclk,
    output logic dr_n,
    output logic sdo
);
    logic      rx_s, cd_s, carrier_on, rx_en, tick, load, sclk_rise;
    rx_frame_t frame;

    fsk_sync2 #(.RST_VAL(1'b1)) u_rx_sync (
        .clk(clk), .rst(rst), .d(rx_raw), .q(rx_s)
    );
    fsk_sync2 #(.RST_VAL(1'b1)) u_cd_sync (
        .clk(clk), .rst(rst), .d(cd_n), .q(cd_s)
    );

    assign carrier_on = ~cd_s;
    assign rx_en      = carrier_on & ~pwr_dn;

    fsk_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .en(~pwr_dn), .tick(tick)
    );

    fsk_char_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .enable(rx_en), .tick(tick),
        .rx_s(rx_s), .load(load), .frame(frame)
    );

    fsk_readout #(.OVS(OVS)) u_out (
        .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .carrier_on(carrier_on),
        .tick(tick), .sclk(sclk), .load(load), .image(frame_image(frame)),
        .sclk_rise(sclk_rise), .dr_n(dr_n), .sdo(sdo)
    );
endmodule

// File: rtl/fsk_byte_reader_chk.sv
module fsk_byte_reader_chk #(
    parameter int TICK_DIV = 13021,
    parameter int OVS      = 16
) (
    input logic clk,
    input logic rst,
    input logic pwr_dn,
    input logic dr_n,
    input logic sdo,
    input logic load,
    input logic carrier_on,
    input logic sclk_rise
);
    localparam int HOLD_CYC = (OVS / 2) * TICK_DIV + 2;

    int low_cnt;

    a_r7_pd_outputs_high: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> (sdo && dr_n));

    a_r2_load_sets_ready: assert property (@(posedge clk) disable iff (rst)
        (load && !pwr_dn && carrier_on) |=> !dr_n);

    a_r6_no_load_without_carrier: assert property (@(posedge clk) disable iff (rst)
        (!carrier_on && !$past(carrier_on)) |-> !load);

    a_r6_ready_high_without_carrier: assert property (@(posedge clk) disable iff (rst)
        !carrier_on |=> dr_n);

    a_r4_rise_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && !load) |=> dr_n);

    always_ff @(posedge clk) begin
        if (rst || dr_n) low_cnt <= 0;
        else             low_cnt <= low_cnt + 1;
        if (!rst) begin
            a_r5_ready_bounded: assert (low_cnt <= HOLD_CYC)
                else $error("ready strobe held low too long");
        end
    end
endmodule

bind fsk_byte_reader fsk_byte_reader_chk #(.TICK_DIV(TICK_DIV), .OVS(OVS)) u_chk (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .dr_n(dr_n), .sdo(sdo),
    .load(load), .carrier_on(carrier_on), .sclk_rise(sclk_rise)
);

// File: tb/sim_fsk_byte_reader.sv
`timescale 1ns/1ps
module sim_fsk_byte_reader;
    localparam int TDIV = 4;
    localparam int OVS  = 16;
    localparam int BIT  = TDIV * OVS;

    logic clk = 1'b0, rst = 1'b1, pwr_dn = 1'b0, cd_n = 1'b1, rx_raw = 1'b1, sclk = 1'b0;
    logic dr_n, sdo;

    int errors = 0, checks = 0, cyc = 0, start_cyc = 0;
    logic [8:0] exp_q[$];
    bit auto_read = 1'b0;
    int read_len = 9, extra_n = 0;

    fsk_byte_reader #(.TICK_DIV(TDIV), .OVS(OVS)) u0 (
        .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .cd_n(cd_n), .rx_raw(rx_raw),
        .sclk(sclk), .dr_n(dr_n), .sdo(sdo)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic stp, input bit expect_it);
        if (expect_it) exp_q.push_back({stp, d});
        @(negedge clk);
        rx_raw = 1'b0;
        start_cyc = cyc;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_raw = d[i];
            repeat (BIT) @(negedge clk);
        end
        rx_raw = stp;
        repeat (BIT) @(negedge clk);
        rx_raw = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    task automatic read_bits(input int n, output logic [8:0] got, output logic dr_after_first);
        got = '1;
        dr_after_first = 1'b0;
        for (int i = 0; i < n; i++) begin
            got[i] = sdo;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            if (i == 0) dr_after_first = dr_n;
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    // Monitor: pops expected frames as the design raises its strobe.
    initial begin
        logic [8:0] got, expv, mask;
        logic       dr1;
        int         lat;
        forever begin
            @(negedge clk);
            if (auto_read && !dr_n) begin
                lat = cyc - start_cyc;
                check(lat >= 596 && lat <= 636, "R2 strobe at stop-bit centre", lat, 612);
                read_bits(read_len, got, dr1);
                check(dr1 == 1'b1, "R4 first sclk edge clears dr_n", dr1, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected character", got, 0);
                end else begin
                    expv = exp_q.pop_front();
                    mask = 9'((1 << read_len) - 1);
                    check((got & mask) == (expv & mask),
                          read_len == 9 ? "R3 R10 serial frame" : "R8 eight-bit read", got & mask, expv & mask);
                end
                for (int k = 0; k < extra_n; k++) begin
                    read_bits(1, got, dr1);
                    check(sdo == 1'b1, "R9 ones after nine shifts", sdo, 1);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [8:0] got;
        logic       dr1;
        int         lows, fall;

        repeat (10) @(negedge clk);
        check(dr_n == 1'b1, "R5 reset dr_n", dr_n, 1);
        check(sdo == 1'b1, "R3 reset register ones", sdo, 1);
        rst = 1'b0;
        cd_n = 1'b0;
        repeat (2 * BIT) @(negedge clk);

        // R3 R9: full reads of several patterns plus extra clocks
        auto_read = 1'b1; read_len = 9; extra_n = 2;
        send_frame(8'hA5, 1'b1, 1'b1);
        send_frame(8'h00, 1'b1, 1'b1);
        send_frame(8'hFF, 1'b1, 1'b1);
        send_frame(8'h3C, 1'b1, 1'b1);
        send_frame(8'h81, 1'b1, 1'b1);
        extra_n = 0;

        // R10: low stop bit stored as received
        send_frame(8'h5A, 1'b0, 1'b1);

        // R8: eight-clock read, then next character overwrites the remainder
        read_len = 8;
        send_frame(8'h96, 1'b1, 1'b1);
        read_len = 9;
        send_frame(8'h0F, 1'b1, 1'b1);

        // R1: short low pulse is not a start bit
        @(negedge clk); rx_raw = 1'b0;
        repeat (12) @(negedge clk); rx_raw = 1'b1;
        lows = 0;
        repeat (3 * BIT) begin @(negedge clk); if (!dr_n) lows++; end
        check(lows == 0, "R1 glitch rejected", lows, 0);
        send_frame(8'hC6, 1'b1, 1'b1);
        check(exp_q.size() == 0, "R1 queue drained", exp_q.size(), 0);

        // R5: strobe times out after half a bit without sclk
        auto_read = 1'b0;
        fork send_frame(8'hC3, 1'b1, 1'b0); join_none
        fall = 0;
        for (int w = 0; w < 14 * BIT && fall == 0; w++) begin
            @(negedge clk);
            if (!dr_n) fall = cyc;
        end
        check(fall != 0, "R5 strobe seen", fall, 1);
        repeat (28) @(negedge clk);
        check(dr_n == 1'b0, "R5 still low before half bit", dr_n, 0);
        repeat (8) @(negedge clk);
        check(dr_n == 1'b1, "R5 released after half bit", dr_n, 1);
        wait fork;

        // R6: without carrier nothing is received and the held byte survives
        cd_n = 1'b1;
        repeat (4) @(negedge clk);
        fork send_frame(8'h55, 1'b1, 1'b0); join_none
        lows = 0;
        repeat (12 * BIT) begin @(negedge clk); if (!dr_n) lows++; end
        wait fork;
        check(lows == 0, "R6 dr_n high without carrier", lows, 0);
        cd_n = 1'b0;
        repeat (BIT) @(negedge clk);
        read_bits(9, got, dr1);
        check(got == 9'h1C3, "R6 register not updated", got, 9'h1C3);

        // R7: power-down forces outputs high
        fork send_frame(8'h00, 1'b1, 1'b0); join_none
        wait fork;
        check(sdo == 1'b0, "R3 head bit visible before clocks", sdo, 0);
        pwr_dn = 1'b1;
        repeat (3) @(negedge clk);
        check(sdo == 1'b1 && dr_n == 1'b1, "R7 outputs high in power-down", {sdo, dr_n}, 2'b11);
        fork send_frame(8'h42, 1'b1, 1'b0); join_none
        lows = 0;
        repeat (12 * BIT) begin @(negedge clk); if (!dr_n || !sdo) lows++; end
        wait fork;
        check(lows == 0, "R7 nothing received in power-down", lows, 0);
        pwr_dn = 1'b0;
        repeat (2 * BIT) @(negedge clk);
        auto_read = 1'b1;
        send_frame(8'h24, 1'b1, 1'b1);
        repeat (BIT) @(negedge clk);
        check(exp_q.size() == 0, "R7 receive after power-down", exp_q.size(), 0);

        finish_run();
    end
endmodule